// File: doc/BRIEF.md
# Prioritized Interrupt Status Aggregator

This block collects four single-cycle event pulses (transmit, receive, power-up, power-down) into sticky status flags. Software reaches them through a small register bus. It can enable each event through a mask, force flags for diagnostics, and drop flags by writing ones. One combined interrupt request goes to the processor.

An index register reports the single most urgent enabled event as a small code. When the processor reads that register, the reported event is acknowledged in the same cycle. The next read then shows the event that follows. A read made on behalf of a debugger is flagged by a sideband input and only observes the state, so a halted system can be inspected without losing events.

Read data is combinational: it is valid in the same cycle as the read strobe. Every state change, including an acknowledge, lands on the following rising clock edge.

Top module: `evt_irq_aggr`

## Requirements
- R1: After synchronous reset, the mask, the raw flags, the masked flags, the index and `irq` are all zero, so every event is masked out.
- R2: An event pulse on `evt_in[i]` sets raw flag i at the next edge, whatever the mask holds. The flag bits are 0 transmit, 1 receive, 2 power-up and 3 power-down, and the raw flags read at offset 0x10.
- R3: The masked flags at offset 0x18 equal the raw flags ANDed with the mask. `irq` is high exactly when any masked flag is set.
- R4: Writing 1 to a bit at offset 0x20 sets that raw flag. Writing 0 leaves the flag unchanged.
- R5: Writing 1 to a bit at offset 0x28 clears that raw flag, even when the flag is masked off. Writing 0 leaves the flag unchanged.
- R6: The index at offset 0x00 reads 0 when no masked flag is set. Otherwise it reads 1 for transmit, 2 for receive, 3 for power-up and 4 for power-down, and the smallest nonzero code among the masked flags wins.
- R7: A read of the index with `bus_dbg` low clears the raw flag of the reported event. The next index read shows the next pending enabled event, or 0 when none is left.
- R8: A read of the index with `bus_dbg` high changes no flag, and repeated reads return the same code.
- R9: When an event pulse meets a clear of the same bit in the same cycle, the flag ends up set.
- R10: The mask at offset 0x08 is read/write and keeps only its low four bits. Bits above bit 3 read as zero in every register.
- R11: The event-mode word at offset 0x30 always reads 1, meaning software clears the flags. Writes to it, and writes to offsets 0x00 and 0x18, change nothing. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_dbg | input | 1 | High when the access comes from the debug path |
| evt_in | input | 4 | Event pulses, one bit per source |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is due in the same cycle as the strobe. The bench therefore samples `bus_rdata` one time unit after it drives the strobe on a falling edge, before the next rising edge. Writes, event pulses and acknowledges take effect at the next rising edge, so a read issued on the falling edge that follows observes them. `irq` follows the flags with no further register, so it is checked in that same falling-edge window. Acknowledge chains issue back-to-back reads to confirm that each read sees the state left by the previous one.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_EVT = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int CODE_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_INDEX  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_SET    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h30;

    localparam logic [1:0] MODE_SW_CLEAR = 2'd1;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE  = 8'd0,
        CODE_TX    = 8'd1,
        CODE_RX    = 8'd2,
        CODE_PWRUP = 8'd3,
        CODE_PWRDN = 8'd4
    } evt_code_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        evt_vec_t          pick;
    } prio_t;

    typedef struct packed {
        evt_vec_t set_vec;
        evt_vec_t clr_vec;
    } flag_upd_t;

    // Lowest bit index wins; code is bit index plus one.
    function automatic prio_t prio_pick(evt_vec_t pend);
        prio_t r;
        logic  found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (pend[i] && !found) begin
                found  = 1'b1;
                r.code = CODE_W'(i + 1);
                r.pick = evt_vec_t'(1) << i;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_upd_t upd,
    output evt_vec_t  raw
);

    genvar g;
    generate
        for (g = 0; g < NUM_EVT; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    raw[g] <= 1'b0;
                else if (upd.set_vec[g])
                    raw[g] <= 1'b1;
                else if (upd.clr_vec[g])
                    raw[g] <= 1'b0;
            end
        end
    endgenerate

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        upd.set_vec != '0 |=> (raw & $past(upd.set_vec)) == $past(upd.set_vec)); // R4

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (upd.clr_vec & ~upd.set_vec) != '0 |=> (raw & $past(upd.clr_vec & ~upd.set_vec)) == '0); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (upd.set_vec == '0 && upd.clr_vec == '0) |=> $stable(raw)); // R8

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t masked,
    output prio_t    sel
);

    always_comb sel = prio_pick(masked);

    AST_IDX_ZERO_IFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) == (sel.code == '0)); // R6

    AST_IDX_POINTS_PENDING: assert property (@(posedge clk) disable iff (rst)
        sel.code != '0 |-> ((sel.pick & masked) != '0 && ((sel.pick - 1'b1) & masked) == '0)); // R6

    AST_PICK_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel.pick)); // R6

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_dbg,
    input  evt_vec_t          evt_in,
    input  evt_vec_t          raw,
    input  prio_t             sel,
    output evt_vec_t          mask,
    output evt_vec_t          masked,
    output flag_upd_t         upd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - NUM_EVT;

    logic     cpu_pop;
    evt_vec_t wdata_evt;

    assign wdata_evt = bus_wdata[NUM_EVT-1:0];
    assign cpu_pop   = bus_rd && !bus_dbg && (bus_addr == OFS_INDEX);
    assign masked    = raw & mask;

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (bus_wr && bus_addr == OFS_MASK)
            mask <= wdata_evt;
    end

    always_comb begin
        upd.set_vec = evt_in;
        upd.clr_vec = '0;
        if (bus_wr && bus_addr == OFS_SET)
            upd.set_vec = upd.set_vec | wdata_evt;
        if (bus_wr && bus_addr == OFS_CLEAR)
            upd.clr_vec = wdata_evt;
        if (cpu_pop)
            upd.clr_vec = upd.clr_vec | sel.pick;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_INDEX:  bus_rdata = DATA_W'(sel.code);
                OFS_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask};
                OFS_RAW:    bus_rdata = {{PAD_W{1'b0}}, raw};
                OFS_MASKED: bus_rdata = {{PAD_W{1'b0}}, masked};
                OFS_MODE:   bus_rdata = DATA_W'(MODE_SW_CLEAR);
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_POP_ACKS: assert property (@(posedge clk) disable iff (rst)
        (cpu_pop && sel.pick != '0 && (sel.pick & evt_in) == '0) |=> (raw & $past(sel.pick)) == '0); // R7

    AST_DBG_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_dbg && !bus_wr && evt_in == '0) |=> $stable(raw)); // R8

    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_in != '0 |=> (raw & $past(evt_in)) == $past(evt_in)); // R9

endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_dbg,
    input  logic [3:0]        evt_in,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    evt_vec_t  raw;
    evt_vec_t  mask;
    evt_vec_t  masked;
    prio_t     sel;
    flag_upd_t upd;

    evt_reg_port u_port (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_dbg   (bus_dbg),
        .evt_in    (evt_in),
        .raw       (raw),
        .sel       (sel),
        .mask      (mask),
        .masked    (masked),
        .upd       (upd),
        .bus_rdata (bus_rdata)
    );

    evt_flag_bank u_bank (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .raw (raw)
    );

    evt_prio_pick u_pick (
        .clk    (clk),
        .rst    (rst),
        .masked (masked),
        .sel    (sel)
    );

    assign irq = |masked;

    AST_IRQ_MATCHES_INDEX: assert property (@(posedge clk) disable iff (rst)
        irq == (sel.code != '0)); // R3

    AST_MASKED_IN_RAW: assert property (@(posedge clk) disable iff (rst)
        (masked & ~raw) == '0); // R3

endmodule

// File: tb/evt_irq_aggr_bench.sv
module evt_irq_aggr_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_dbg;
    logic [3:0]  evt_in;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_aggr u_evt_irq_aggr (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_dbg(bus_dbg),
        .evt_in(evt_in), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    task automatic idle_bus;
        bus_rd = 0; bus_wr = 0; bus_dbg = 0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_bus();
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd(input logic [7:0] a, input logic dbg, output logic [31:0] d);
        @(negedge clk);
        idle_bus();
        bus_rd = 1; bus_addr = a; bus_dbg = dbg;
        #1 d = bus_rdata;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        idle_bus();
        evt_in = v;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h08, 0, d); check("R1 mask", d, 0);
        rd(8'h10, 0, d); check("R1 raw", d, 0);
        rd(8'h18, 0, d); check("R1 masked", d, 0);
        rd(8'h00, 1, d); check("R1 index", d, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_raw_and_mask;
        logic [31:0] d;
        pulse(4'b0110);
        rd(8'h10, 0, d); check("R2 raw from pulses while masked", d, 32'h6);
        check("R3 irq low while masked", {31'd0, irq}, 0);
        wr(8'h08, 32'h0000_0004);
        rd(8'h18, 0, d); check("R3 masked=raw&mask", d, 32'h4);
        check("R3 irq high", {31'd0, irq}, 1);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 0, d); check("R10 mask keeps low bits", d, 32'hF);
        wr(8'h28, 32'hF);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] d;
        wr(8'h20, 32'h9);
        rd(8'h10, 0, d); check("R4 set writes ones", d, 32'h9);
        wr(8'h20, 32'h0);
        rd(8'h10, 0, d); check("R4 zero set no effect", d, 32'h9);
        wr(8'h28, 32'h0);
        rd(8'h10, 0, d); check("R5 zero clear no effect", d, 32'h9);
        wr(8'h28, 32'h8);
        rd(8'h10, 0, d); check("R5 clear while masked", d, 32'h1);
        wr(8'h28, 32'hF);
    endtask

    task automatic t_priority_pop;
        logic [31:0] d;
        wr(8'h20, 32'hF);
        wr(8'h08, 32'h4);
        rd(8'h00, 1, d); check("R6 mask selects pwrup", d, 3);
        wr(8'h08, 32'hF);
        rd(8'h00, 0, d); check("R7 pop tx", d, 1);
        rd(8'h00, 0, d); check("R7 pop rx", d, 2);
        rd(8'h10, 0, d); check("R7 raw after two pops", d, 32'hC);
        rd(8'h00, 0, d); check("R7 pop pwrup", d, 3);
        rd(8'h00, 0, d); check("R6 pop pwrdn", d, 4);
        rd(8'h00, 0, d); check("R7 none left", d, 0);
        check("R3 irq drops", {31'd0, irq}, 0);
        wr(8'h20, 32'hA);
        rd(8'h00, 1, d); check("R6 rx beats pwrdn", d, 2);
        wr(8'h28, 32'hF);
    endtask

    task automatic t_debug_read;
        logic [31:0] d;
        wr(8'h20, 32'h3);
        rd(8'h00, 1, d); check("R8 dbg read code", d, 1);
        rd(8'h00, 1, d); check("R8 dbg read repeat", d, 1);
        rd(8'h10, 0, d); check("R8 raw untouched", d, 32'h3);
        wr(8'h28, 32'hF);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk);
        idle_bus();
        bus_wr = 1; bus_addr = 8'h28; bus_wdata = 32'h2; evt_in = 4'b0010;
        @(negedge clk);
        idle_bus();
        rd(8'h10, 0, d); check("R9 pulse beats clear", d, 32'h2);
        wr(8'h20, 32'h1);
        @(negedge clk);
        idle_bus();
        bus_rd = 1; bus_addr = 8'h00; evt_in = 4'b0001;
        #1 d = bus_rdata; check("R7 pop code during pulse", d, 1);
        @(negedge clk);
        idle_bus();
        rd(8'h10, 0, d); check("R9 pulse beats pop", d, 32'h3);
        wr(8'h28, 32'hF);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        rd(8'h30, 0, d); check("R11 mode reads one", d, 1);
        wr(8'h30, 32'h0);
        rd(8'h30, 0, d); check("R11 mode write ignored", d, 1);
        rd(8'h04, 0, d); check("R11 unmapped reads zero", d, 0);
        rd(8'h40, 0, d); check("R11 unmapped high", d, 0);
        wr(8'h18, 32'hF);
        wr(8'h00, 32'hF);
        rd(8'h10, 0, d); check("R11 writes to ro ignored", d, 0);
        wr(8'h20, 32'hFFFF_FFF0);
        rd(8'h10, 0, d); check("R10 upper set bits dropped", d, 0);
    endtask

    initial begin
        idle_bus();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_raw_and_mask();
        t_set_clear();
        t_priority_pop();
        t_debug_read();
        t_collision();
        t_map();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

endmodule